// File: doc/BRIEF.md
# Successive-Approximation Register Controller

This block is the digital half of a successive-approximation analog-to-digital converter. It drives an N-bit trial code to an external DAC and reads back one comparator bit per clock. That bit is high when the DAC output lies above the held input sample. A single-cycle start request in the idle state begins a conversion. The block then settles one bit per clock period, working from the most significant bit down to the least.

In each period the trial bit under test is already set on the code output. At the closing clock edge the block keeps or clears that bit according to the comparator and sets the next lower bit for the following trial. After N periods the final code is copied into a result register. A one-cycle done pulse marks this, and the result stays unchanged until the next accepted start. The DAC, comparator and sample-and-hold sit outside the block. The DAC is expected to be shifted down by half an LSB, so that every output code covers a band centred on its nominal level.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears `busy`, `done`, `trial` and `result` to zero.
- R2: A `start` that is high at an edge while the block is idle makes `busy` high after that edge and sets `trial` to the MSB alone (bit N-1 = 1, all other bits 0). The same edge clears `result` to zero.
- R3: At each edge while busy, the bit under test (bit N-1 first, then downward) is cleared when `cmp_above` is 1 and kept at 1 when `cmp_above` is 0. Higher bits are not changed, and the next lower bit is set to 1 for the following trial.
- R4: `busy` stays high for exactly N cycles after the accepting edge. At the Nth edge `busy` falls and `done` rises for exactly one cycle.
- R5: At the edge that raises `done`, `result` takes the completed code. It then holds that value while the block is idle until the next accepted start.
- R6: A `start` that is high while `busy` is high has no effect on the trial sequence, on the cycle `done` appears, or on the result.
- R7: With a DAC shifted down by half an LSB, the result equals the input rounded to the nearest code (a tie rounds up), and it saturates at 2^N-1 for inputs above full scale.
- R8: With N=4, a 16 V span and a 10.8 V input, the trial codes are 1000, 1100, 1010, 1011 in turn and the result is 1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_above | input | 1 | Comparator: 1 when the DAC output is above the held input |
| trial | output | N | Code driven to the DAC |
| busy | output | 1 | High while bits are being resolved |
| done | output | 1 | One-cycle pulse when the result becomes valid |
| result | output | N | Final code, held until the next start |

## Verification
The 4-bit reference input is run with the trial code sampled every period, so a wrong bit order or a misplaced keep/clear decision shows up in a specific step. An 8-bit instance is swept over stepped inputs across the full range, including inputs above full scale. It is also driven at each code's exact lower band edge and a tenth of an LSB below it. These edge cases separate correct half-LSB rounding from truncation and from a reversed comparison. Extra start pulses in mid-conversion and a reset in mid-conversion show whether the sequence can be restarted or corrupted.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation controller.
// Assumes nothing beyond a two-state control flow.
package sar_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
// Sequencer: tracks idle/converting state and the index of the bit under
// test, raises the done pulse. Assumes N >= 2 and a synchronous active-low reset.
module sar_seq
    import sar_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          load,
    output logic          last,
    output logic          done,
    output logic [IW-1:0] ptr
);
    sar_state_e state_q;

    // Decode handy control strobes from the state and bit index.
    always_comb begin
        busy = (state_q == ST_CONV);
        load = (state_q == ST_IDLE) && start;
        last = busy && (ptr == '0);
    end

    // Advance state and bit index; emit done after the final decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr     <= '0;
            done    <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                state_q <= ST_CONV;
                ptr     <= IW'(N - 1);
            end else if (last) begin
                state_q <= ST_IDLE;
            end else if (busy) begin
                ptr <= ptr - 1'b1;
            end
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ptr != '0) |=> (busy && ptr == $past(ptr) - 1'b1)); // R3 R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4
endmodule

// File: rtl/sar_code.sv
// Code register: holds the trial code and the final result. Each bit has
// its own update rule, chosen by the bit index supplied by the sequencer.
// Assumes cmp_above is valid for the trial code present in the same cycle.
module sar_code #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          busy,
    input  logic          last,
    input  logic [IW-1:0] ptr,
    input  logic          cmp_above,
    output logic [N-1:0]  trial,
    output logic [N-1:0]  result
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;

        // Per-bit rule: seed MSB, decide the bit under test, arm the next one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (load) begin
                bit_q <= (i == N - 1);
            end else if (busy) begin
                if (int'(ptr) == i) begin
                    bit_q <= ~cmp_above;
                end else if (int'(ptr) == i + 1) begin
                    bit_q <= 1'b1;
                end
            end
        end

        assign trial[i] = bit_q;
    end

    // Capture the completed code on the last decision; clear on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (load) begin
            result <= '0;
        end else if (last) begin
            result <= {trial[N-1:1], ~cmp_above};
        end
    end

    AST_CLEAR_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmp_above) |=> (trial[$past(ptr)] == 1'b0)); // R3
    AST_KEEP_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmp_above) |=> (trial[$past(ptr)] == 1'b1)); // R3
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(result)); // R5
endmodule

// File: rtl/sar_ctrl.sv
// Top of the successive-approximation controller. Joins the sequencer and
// the code register. Assumes an external DAC offset by half an LSB and a
// comparator that settles within one clock period.
module sar_ctrl #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_above,
    output logic [N-1:0] trial,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] result
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    logic          load;
    logic          last;
    logic [IW-1:0] ptr;

    sar_seq #(.N(N)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .load  (load),
        .last  (last),
        .done  (done),
        .ptr   (ptr)
    );

    sar_code #(.N(N)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .busy      (busy),
        .last      (last),
        .ptr       (ptr),
        .cmp_above (cmp_above),
        .trial     (trial),
        .result    (result)
    );

    AST_START_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && trial == MSB_ONLY && result == '0)); // R2
endmodule

// File: tb/tb_sar_ctrl.sv
`timescale 1ns/100ps
module tb_sar_ctrl;
    localparam int N  = 8;
    localparam int NR = 4;
    localparam int MAXC = (1 << N) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic start_r = 1'b0;
    int   vin10 = 0;   // input in tenths of an LSB
    int   vin10_r = 0;
    int   total = 0;
    int   bad = 0;

    logic [N-1:0]  trial, result;
    logic          busy, done, cmp_above;
    logic [NR-1:0] trial_r, result_r;
    logic          busy_r, done_r, cmp_r;

    always #2.5 clk = ~clk;

    // Ideal DAC shifted down half an LSB, compared with the input.
    assign cmp_above = (10 * int'(trial) - 5) > vin10;
    assign cmp_r     = (10 * int'(trial_r) - 5) > vin10_r;

    sar_ctrl #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_above(cmp_above),
        .trial(trial), .busy(busy), .done(done), .result(result)
    );

    sar_ctrl #(.N(NR)) dut_ref (
        .clk(clk), .rst_n(rst_n), .start(start_r), .cmp_above(cmp_r),
        .trial(trial_r), .busy(busy_r), .done(done_r), .result(result_r)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ideal(input int v);
        int c;
        c = (v + 5) / 10;
        return (c > MAXC) ? MAXC : c;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 trial", int'(trial), 0);
        check("R1 result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One conversion on the 8-bit instance; extra starts optional.
    task automatic convert(input int v, input bit noisy, input bit full);
        int got;
        vin10 = v;
        start = 1'b1;
        @(negedge clk);
        start = noisy;
        if (full) begin
            check("R2 busy", int'(busy), 1);
            check("R2 trial", int'(trial), 1 << (N - 1));
            check("R2 result cleared", int'(result), 0);
        end
        for (int k = 1; k < N; k++) begin
            @(negedge clk);
            if (full) check("R4 busy held", int'(busy) + 2 * int'(done), 1);
        end
        @(negedge clk);
        start = 1'b0;
        check("R4 done", int'(done), 1);
        if (full) check("R4 busy low", int'(busy), 0);
        got = int'(result);
        check(noisy ? "R6 result" : "R7 result", got, ideal(v));
        if (full) begin
            @(negedge clk);
            check("R4 done one cycle", int'(done), 0);
            vin10 = 0;
            repeat (3) @(negedge clk);
            check("R5 result held", int'(result), got);
        end
    endtask

    task automatic t_reference();
        int seq[4] = '{8, 12, 10, 11};
        vin10_r = 108;
        start_r = 1'b1;
        @(negedge clk);
        start_r = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R8 trial step", int'(trial_r), seq[k]);
            @(negedge clk);
        end
        check("R8 done", int'(done_r), 1);
        check("R8 result", int'(result_r), 11);
    endtask

    task automatic t_sweep();
        for (int v = 0; v <= 10 * MAXC + 40; v += 7) convert(v, 1'b0, 1'b0);
    endtask

    task automatic t_edges();
        for (int c = 1; c <= MAXC; c++) begin
            convert(10 * c - 5, 1'b0, 1'b0);
            convert(10 * c - 6, 1'b0, 1'b0);
        end
    endtask

    task automatic t_busy_start();
        convert(1234, 1'b1, 1'b1);
        convert(7, 1'b1, 1'b0);
    endtask

    task automatic t_mid_reset();
        vin10 = 900;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        convert(555, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_reference();
        convert(1280, 1'b0, 1'b1);
        convert(0, 1'b0, 1'b1);
        convert(10 * MAXC + 100, 1'b0, 1'b1);
        t_busy_start();
        t_mid_reset();
        t_sweep();
        t_edges();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule